// File: doc/BRIEF.md
# Multi-domain clock enable generator

This block runs on the main system clock and produces one single-cycle enable strobe per domain per derived period. The domains are:

- a bus domain;
- a processor domain and a copy of it delayed by two cycles;
- four peripheral domains, each with its own programmable divider;
- two asynchronous-peripheral domains that take their strobes from the first peripheral domain.

Logic in each domain advances only on cycles where its strobe is high, so the whole design stays on one clock tree. No clock is gated.

Software supplies the following:

- a disable vector, where each domain owns one bit at a fixed position;
- per-domain divider fields;
- a self-test flag with its own processor divider;
- a write strobe that commits the divider fields.

A write is checked before it is accepted. The second peripheral domain must run at an integer multiple of the first one's rate. A write that breaks this rule is dropped whole and sets a sticky error flag. Accepted settings take effect at the next terminal count of each domain's counter. A period already in progress therefore always completes at its old length.

Top module: `clk_en_gen`

## Requirements
- R1: While `rst_ni` is low, all dividers are set to divide by 1, all domains are enabled, all counters are cleared and `div_err_o` is low. After release, `bus_en_o`, `cpu_en_o`, all of `per_en_o` and all of `aper_en_o` are high every cycle. `cpu_dly_en_o` is low after the first clock edge and high from the second.
- R2: `bus_en_o` is high on every cycle unless the bus domain's disable bit is set.
- R3: With `selftest_i` low, `cpu_en_o` pulses on every cycle, in step with `bus_en_o`. With `selftest_i` high, it pulses once every `st_div_i`+1 cycles. The field is 3 bits and holds the divisor minus one, so it covers divisors 1 to 8.
- R4: `cpu_dly_en_o` equals the value `cpu_en_o` had two cycles earlier, for as long as disable bit 0 stays clear.
- R5: Peripheral domain k pulses once every `per_div_i[k]`+1 cycles. Each field is 4 bits and holds the divisor minus one, so it covers divisors 1 to 16. A field of 0 keeps the strobe high continuously.
- R6: `dis_i` is sampled on each clock edge. A set bit forces its domain's strobe low from the following cycle. The bit positions are:
  - bit 0: processor domain and its delayed copy;
  - bit 1: bus domain;
  - bits 2 and 3: peripheral domains 0 and 1;
  - bits 8 and 9: peripheral domains 2 and 3;
  - bits 4 and 5: asynchronous domains 0 and 1.

  Bits 6 and 7 have no effect.
- R7: When a processor or peripheral domain is re-enabled, its counter restarts from zero. Its first strobe falls on cycle index D-1 after the first enabled cycle, where D is the divisor and the first enabled cycle is index 0.
- R8: A high `div_we_i` commits `per_div_i` and `st_div_i` on that edge. A running domain switches to the new divisor only after its current period ends. No period shorter or longer than either the old or the new divisor ever appears.
- R9: The write is rejected when (`per_div_i[0]`+1) is not an integer multiple of (`per_div_i[1]`+1). A rejected write leaves every divider unchanged and sets `div_err_o`, which then stays high until reset.
- R10: Asynchronous domain j repeats the strobes of peripheral domain 0's counter, gated only by its own disable bit. It keeps running while peripheral domain 0's own strobe is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dis_i | input | 10 | Domain disable vector, fixed bit positions (R6) |
| div_we_i | input | 1 | Commit strobe for the divider fields |
| per_div_i | input | 4x4 (16) | Peripheral divider fields, divisor minus one; element k feeds domain k |
| st_div_i | input | 3 | Self-test processor divider, divisor minus one |
| selftest_i | input | 1 | Self-test mode; allows the processor domain to be divided |
| bus_en_o | output | 1 | Bus domain strobe |
| cpu_en_o | output | 1 | Processor domain strobe |
| cpu_dly_en_o | output | 1 | Processor strobe delayed by two cycles |
| per_en_o | output | 4 | Peripheral domain strobes |
| aper_en_o | output | 2 | Asynchronous-peripheral domain strobes |
| div_err_o | output | 1 | Sticky flag for a rejected divider write |

## Verification
The divider is tried with several divisor mixes (1, 2, 4, 5, 8 and 16) over windows that every divisor divides evenly. These windows separate a wrong rate from a wrong phase. A one-hot walk over all ten disable bits, reserved bits included, catches a swapped or missing bit position. Restart and mid-period rewrite sequences are checked cycle by cycle, which exposes an early reload or a counter that fails to clear. Random disables, writes (legal and illegal) and self-test toggles are then compared every cycle against a bench model. This tells a rejected write apart from an accepted one and catches any drift of the delayed copy.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;
  localparam int DIS_W   = 10;
  localparam int NPER    = 4;
  localparam int NAPER   = 2;
  localparam int NDOM    = 2 + NPER + NAPER;
  localparam int DOM_IW  = $clog2(NDOM);
  localparam int DIS_IW  = $clog2(DIS_W);
  localparam int D_CPU   = 0;
  localparam int D_BUS   = 1;
  localparam int D_PER0  = 2;
  localparam int D_APER0 = D_PER0 + NPER;

  // disable bit -> domain index, -1 for reserved bits
  function automatic int dom_of_bit(int b);
    case (b)
      0:       return D_CPU;
      1:       return D_BUS;
      2:       return D_PER0;
      3:       return D_PER0 + 1;
      4:       return D_APER0;
      5:       return D_APER0 + 1;
      8:       return D_PER0 + 2;
      9:       return D_PER0 + 3;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] pend_i,
  output logic         term_o
);
  logic [W-1:0] cnt_q, cur_q;

  assign term_o = (cnt_q == cur_q);

  // reload only at terminal count or while held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (hold_i || term_o) begin
      cnt_q <= '0;
      cur_q <= pend_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cur_q);                                                      // R5
  AST_RELOAD_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cnt_q != cur_q) |=> $stable(cur_q));                      // R8
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));                                            // R7
endmodule

// File: rtl/clk_en_cfg.sv
module clk_en_cfg #(
  parameter int NP = 4,
  parameter int PW = 4,
  parameter int SW = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [NP-1:0][PW-1:0]  pdiv_i,
  input  logic [SW-1:0]          st_div_i,
  output logic [NP-1:0][PW-1:0]  pdiv_o,
  output logic [SW-1:0]          st_div_o,
  output logic                   err_o
);
  logic [NP-1:0][PW-1:0] pdiv_q;
  logic [SW-1:0]         st_q;
  logic                  err_q;
  logic [PW:0]           in_slow, in_fast, q_slow, q_fast;
  logic                  legal;

  // divisors of peripheral 0 (slow) and 1 (fast)
  assign in_slow = {1'b0, pdiv_i[0]} + 1'b1;
  assign in_fast = {1'b0, pdiv_i[1]} + 1'b1;
  assign legal   = ((in_slow % in_fast) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdiv_q <= '0;
      st_q   <= '0;
      err_q  <= 1'b0;
    end else if (we_i) begin
      if (legal) begin
        pdiv_q <= pdiv_i;
        st_q   <= st_div_i;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  assign pdiv_o   = pdiv_q;
  assign st_div_o = st_q;
  assign err_o    = err_q;

  assign q_slow = {1'b0, pdiv_q[0]} + 1'b1;
  assign q_fast = {1'b0, pdiv_q[1]} + 1'b1;

  AST_RATIO_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_slow % q_fast) == '0);                                             // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);                                                     // R9
  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !legal) |=> ($stable(pdiv_q) && $stable(st_q) && err_o));    // R9
endmodule

// File: rtl/clk_en_cpu.sv
module clk_en_cpu #(
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          off_i,
  input  logic          selftest_i,
  input  logic [SW-1:0] st_div_i,
  output logic          cpu_en_o,
  output logic          cpu_dly_o
);
  logic [SW-1:0] pend;
  logic          term;
  logic [1:0]    sh_q;

  // division only allowed in self-test
  assign pend = selftest_i ? st_div_i : '0;

  clk_en_div #(.W(SW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (off_i),
    .pend_i (pend),
    .term_o (term)
  );

  assign cpu_en_o = term & ~off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[0], cpu_en_o};
  end

  assign cpu_dly_o = sh_q[1] & ~off_i;
endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen
  import clk_en_pkg::*;
#(
  parameter int PDIV_W = 4,
  parameter int ST_W   = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DIS_W-1:0]            dis_i,
  input  logic                        div_we_i,
  input  logic [NPER-1:0][PDIV_W-1:0] per_div_i,
  input  logic [ST_W-1:0]             st_div_i,
  input  logic                        selftest_i,
  output logic                        bus_en_o,
  output logic                        cpu_en_o,
  output logic                        cpu_dly_en_o,
  output logic [NPER-1:0]             per_en_o,
  output logic [NAPER-1:0]            aper_en_o,
  output logic                        div_err_o
);
  logic [NDOM-1:0]             off_d, off_q;
  logic [NPER-1:0][PDIV_W-1:0] pdiv_q;
  logic [ST_W-1:0]             st_q;
  logic [NPER-1:0]             per_term;

  always_comb begin
    off_d = '0;
    for (int b = 0; b < DIS_W; b++) begin
      if (dom_of_bit(b) >= 0) off_d[DOM_IW'(dom_of_bit(b))] = dis_i[DIS_IW'(b)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else         off_q <= off_d;
  end

  clk_en_cfg #(.NP(NPER), .PW(PDIV_W), .SW(ST_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (div_we_i),
    .pdiv_i   (per_div_i),
    .st_div_i (st_div_i),
    .pdiv_o   (pdiv_q),
    .st_div_o (st_q),
    .err_o    (div_err_o)
  );

  clk_en_cpu #(.SW(ST_W)) u_cpu (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .off_i      (off_q[D_CPU]),
    .selftest_i (selftest_i),
    .st_div_i   (st_q),
    .cpu_en_o   (cpu_en_o),
    .cpu_dly_o  (cpu_dly_en_o)
  );

  assign bus_en_o = ~off_q[D_BUS];

  for (genvar k = 0; k < NPER; k++) begin : g_per
    logic hold;
    if (k == 0) begin : g_shared
      // counter also feeds the async domains
      assign hold = off_q[D_PER0] & (&off_q[D_APER0 +: NAPER]);
    end else begin : g_own
      assign hold = off_q[D_PER0 + k];
    end

    clk_en_div #(.W(PDIV_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (hold),
      .pend_i (pdiv_q[k]),
      .term_o (per_term[k])
    );

    assign per_en_o[k] = per_term[k] & ~off_q[D_PER0 + k];
  end

  for (genvar j = 0; j < NAPER; j++) begin : g_aper
    assign aper_en_o[j] = per_term[0] & ~off_q[D_APER0 + j];
  end

  AST_APER_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_q[D_PER0] && !off_q[D_APER0]) |-> (aper_en_o[0] == per_en_o[0])); // R10
endmodule

// File: tb/clk_en_gen_bench.sv
`timescale 1ns/1ps
module clk_en_gen_bench;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [9:0]      dis = '0;
  logic            we = 1'b0;
  logic [3:0][3:0] pd = '0;
  logic [2:0]      st = '0;
  logic            stest = 1'b0;
  logic            bus_en, cpu_en, dly_en, err;
  logic [3:0]      per_en;
  logic [1:0]      aper_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_en_gen u_clk_en_gen (
    .clk_i(clk), .rst_ni(rst_n), .dis_i(dis), .div_we_i(we), .per_div_i(pd),
    .st_div_i(st), .selftest_i(stest), .bus_en_o(bus_en), .cpu_en_o(cpu_en),
    .cpu_dly_en_o(dly_en), .per_en_o(per_en), .aper_en_o(aper_en), .div_err_o(err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  // counter 0: processor; counters 1..4: peripheral 0..3
  logic [9:0] md;
  int m_cnt[5], m_cur[5], m_pp[4], m_ps;
  bit m_err;
  bit [1:0] m_sh;

  function automatic int pbit(int k);
    return (k < 2) ? 2 + k : 6 + k;
  endfunction
  function automatic bit legal(int a, int b);
    return ((a + 1) % (b + 1)) == 0;
  endfunction
  function automatic bit mterm(int i);
    return m_cnt[i] == m_cur[i];
  endfunction
  function automatic bit e_cpu();
    return mterm(0) && !md[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md = '0; m_err = 0; m_sh = '0; m_ps = 0;
      for (int i = 0; i < 5; i++) begin m_cnt[i] = 0; m_cur[i] = 0; end
      for (int k = 0; k < 4; k++) m_pp[k] = 0;
    end else begin
      m_sh = {m_sh[0], e_cpu()};
      for (int i = 0; i < 5; i++) begin
        bit h;
        int p;
        if (i == 0) h = md[0];
        else if (i == 1) h = md[2] && md[4] && md[5];
        else h = md[pbit(i - 1)];
        p = (i == 0) ? (stest ? m_ps : 0) : m_pp[i - 1];
        if (h || mterm(i)) begin m_cnt[i] = 0; m_cur[i] = p; end
        else m_cnt[i] = m_cnt[i] + 1;
      end
      if (we) begin
        if (legal(pd[0], pd[1])) begin
          for (int k = 0; k < 4; k++) m_pp[k] = pd[k];
          m_ps = st;
        end else m_err = 1;
      end
      md = dis;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "bus_en model", bus_en, !md[1]);
      chk("R3", "cpu_en model", cpu_en, e_cpu());
      chk("R4", "cpu_dly_en model", dly_en, m_sh[1] && !md[0]);
      for (int k = 0; k < 4; k++)
        chk("R5", $sformatf("per_en[%0d] model", k), per_en[k], mterm(k + 1) && !md[pbit(k)]);
      for (int j = 0; j < 2; j++)
        chk("R10", $sformatf("aper_en[%0d] model", j), aper_en[j], mterm(1) && !md[4 + j]);
      chk("R9", "div_err model", err, m_err);
    end
  end

  // ---------------- directed helpers ----------------
  function automatic logic [8:0] ovec();
    return {aper_en, per_en, dly_en, cpu_en, bus_en};
  endfunction

  function automatic logic [8:0] emap(int b);
    logic [8:0] v = 9'h1FF;
    case (b)
      0: v[2:1] = 2'b00;
      1: v[0] = 1'b0;
      2: v[3] = 1'b0;
      3: v[4] = 1'b0;
      4: v[7] = 1'b0;
      5: v[8] = 1'b0;
      8: v[5] = 1'b0;
      9: v[6] = 1'b0;
      default: ;
    endcase
    return v;
  endfunction

  int c_bus, c_cpu, c_dly, c_per[4], c_ap[2];

  task automatic count(input int n);
    bit h1 = 0, h2 = 0;
    c_bus = 0; c_cpu = 0; c_dly = 0;
    for (int k = 0; k < 4; k++) c_per[k] = 0;
    for (int j = 0; j < 2; j++) c_ap[j] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_bus += bus_en; c_cpu += cpu_en; c_dly += dly_en;
      for (int k = 0; k < 4; k++) c_per[k] += per_en[k];
      for (int j = 0; j < 2; j++) c_ap[j] += aper_en[j];
      if (i >= 2) chk("R4", "dly vs cpu two cycles back", dly_en, h2);
      h2 = h1; h1 = cpu_en;
    end
  endtask

  task automatic wr(input int p0, input int p1, input int p2, input int p3, input int s);
    pd[0] = 4'(p0); pd[1] = 4'(p1); pd[2] = 4'(p2); pd[3] = 4'(p3); st = 3'(s);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5821));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1", "outputs after first edge", int'(ovec()), int'(9'h1FB));
    chk("R1", "div_err after reset", err, 0);
    @(negedge clk);
    chk("R1", "cpu_dly after second edge", dly_en, 1);

    // R6: one-hot walk over the disable vector
    for (int b = 0; b < 10; b++) begin
      dis = 10'(1 << b);
      @(negedge clk);
      chk("R6", $sformatf("outputs with disable bit %0d", b), int'(ovec()), int'(emap(b)));
      dis = '0;
      repeat (3) @(negedge clk);
    end

    // R10: async domains run on while peripheral 0 is off
    wr(3, 0, 0, 0, 0);
    dis = 10'h004;
    repeat (10) @(negedge clk);
    count(16);
    chk("R10", "aper0 pulses, per0 off", c_ap[0], 4);
    chk("R10", "aper1 pulses, per0 off", c_ap[1], 4);
    chk("R6", "per0 pulses while off", c_per[0], 0);
    dis = '0;

    // R5/R8: rates after a legal write
    wr(3, 1, 4, 15, 0);
    repeat (20) @(negedge clk);
    count(80);
    chk("R5", "per0 div4", c_per[0], 20);
    chk("R5", "per1 div2", c_per[1], 40);
    chk("R5", "per2 div5", c_per[2], 16);
    chk("R5", "per3 div16", c_per[3], 5);
    chk("R2", "bus every cycle", c_bus, 80);

    // R9: illegal ratio write (3 is not a multiple of 2)
    wr(2, 1, 0, 0, 0);
    chk("R9", "err after illegal write", err, 1);
    repeat (4) @(negedge clk);
    count(80);
    chk("R9", "per0 kept div4", c_per[0], 20);
    chk("R9", "per2 kept div5", c_per[2], 16);
    wr(3, 1, 4, 15, 0);
    chk("R9", "err sticky after legal write", err, 1);

    // R3: processor division only in self-test
    count(10);
    chk("R3", "cpu full rate, no self-test", c_cpu, 10);
    stest = 1'b1;
    wr(3, 1, 4, 15, 2);
    repeat (10) @(negedge clk);
    count(12);
    chk("R3", "cpu div3 in self-test", c_cpu, 4);
    chk("R4", "dly div3 in self-test", c_dly, 4);
    wr(3, 1, 4, 15, 7);
    repeat (10) @(negedge clk);
    count(16);
    chk("R3", "cpu div8 in self-test", c_cpu, 2);
    stest = 1'b0;
    repeat (10) @(negedge clk);
    count(8);
    chk("R3", "cpu back to full rate", c_cpu, 8);

    // R7: restart of peripheral 2 (div5) from zero
    dis = 10'h100;
    repeat (3) @(negedge clk);
    dis = '0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R7", $sformatf("per2 restart index %0d", i), per_en[2], (i == 4 || i == 9));
    end

    // R8: mid-period change of peripheral 3 from div8 to div2
    wr(3, 1, 4, 7, 0);
    dis = 10'h200;
    repeat (2) @(negedge clk);
    dis = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R8", $sformatf("per3 change index %0d", i), per_en[3], (i == 7 || i == 9 || i == 11));
      if (i == 2) begin pd[3] = 4'd1; we = 1'b1; end
      else we = 1'b0;
    end

    // random phase, checked against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      we = 1'b0;
      if ($urandom % 16 == 0) dis = 10'($urandom & $urandom);
      if ($urandom % 64 == 0) stest = ~stest;
      if ($urandom % 20 == 0) begin
        int f = $urandom % 16;
        int m = 1 + $urandom % (16 / (f + 1));
        pd[1] = 4'(f);
        pd[0] = ($urandom % 4 == 0) ? 4'($urandom) : 4'((f + 1) * m - 1);
        pd[2] = 4'($urandom);
        pd[3] = 4'($urandom);
        st = 3'($urandom);
        we = 1'b1;
      end
    end
    @(negedge clk);
    we = 1'b0;
    dis = '0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule